// File: doc/BRIEF.md
# Ethernet Controller Command and Status Register File

This block is the host-visible register file of a descriptor-ring Ethernet controller. The host reaches it through two ports. The select port holds a register index. The data port reads or writes the register that index points at. There are four 16-bit registers.

Register 0 is the command and status word. It mixes three kinds of bit:
- event flags that the host clears by writing ones;
- command bits that a write can only set;
- an interrupt-enable bit that the host reads and writes freely.

Two summary bits, an error flag and an interrupt flag, are built from the event flags. The interrupt output is the interrupt flag gated by the enable. Registers 1 to 3 are plain storage for the address and mode words that the DMA engines use.

The init and transmit engines talk to the block through their own inputs:
- one-cycle event-set pulses;
- a pulse that marks init as complete and loads the receiver and transmitter enables;
- a pulse that retires a transmit demand.

The engines read the command bits and the enables through dedicated outputs.

Top module: `enet_csr_file`

## Requirements
- R1: After reset, register 0 reads 0x0004 (only the stop bit set), the select port reads 0, registers 1 to 3 read 0, and `irq` is low.
- R2: A write to the select port (`bus_addr`=1) keeps only bits 1:0 of the written value. A select read returns that index zero-extended. Data-port accesses (`bus_addr`=0) reach the register with that index.
- R3: Register 0 event bits are BABL at bit 14, CERR at 13, MISS at 12, MERR at 11, RINT at 10, TINT at 9 and IDON at 8. Writing 1 to one of these bits clears it. Writing 0 leaves it unchanged.
- R4: TDMD (bit 3), STRT (bit 1) and INIT (bit 0) are set by writing 1, and a written 0 does not clear them. Setting STRT or INIT clears STOP (bit 2).
- R5: A write with the STOP bit set leaves STOP=1 and STRT=INIT=0, even if the same write also sets STRT or INIT.
- R6: INEA (bit 6) takes the written value on every register 0 write.
- R7: ERR (bit 15) reads as the OR of BABL, CERR, MISS and MERR.
- R8: INTR (bit 7) reads as the OR of BABL, MISS, MERR, RINT, TINT and IDON. CERR alone does not raise it.
- R9: While MERR is set, RXON (bit 5) and TXON (bit 4) read 0 and stay cleared. While STOP is set, IDON reads 0, and an IDON set that arrives while STOP is set is lost.
- R10: `irq` equals INTR AND INEA of the current register 0 contents.
- R11: A data-port write to register 1, 2 or 3 stores all 16 bits.
- R12: A pulse on `evt_set` bit k sets the event flag at register 0 bit 8+k. If the host clears a flag in the same cycle that hardware sets it, the flag stays set.
- R13: `clr_init` clears INIT and loads RXON/TXON from `init_rx_en`/`init_tx_en`. `clr_tdmd` clears TDMD. A host write of 1 to the same bit in the same cycle wins over either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe for the port chosen by `bus_addr` |
| bus_addr | input | 1 | 0 = data port, 1 = select port (for reads and writes) |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data for the port chosen by `bus_addr` |
| evt_set | input | 7 | Event-set pulses; bit k sets register 0 bit 8+k |
| clr_init | input | 1 | Init-complete pulse: clears INIT, loads the enables |
| clr_tdmd | input | 1 | Transmit engine retires the transmit demand |
| init_rx_en | input | 1 | Receiver enable loaded on `clr_init` |
| init_tx_en | input | 1 | Transmitter enable loaded on `clr_init` |
| cmd_init | output | 1 | INIT command bit |
| cmd_strt | output | 1 | STRT command bit |
| cmd_stop | output | 1 | STOP command bit |
| cmd_tdmd | output | 1 | Transmit-demand bit |
| rx_on | output | 1 | Effective receiver enable |
| tx_on | output | 1 | Effective transmitter enable |
| irq | output | 1 | Interrupt request |

## Verification
The collisions that matter are a host write-one-to-clear landing in the same cycle as an engine's event-set pulse, and a host command write landing in the same cycle as the `clr_init` or `clr_tdmd` retire pulse. Both are provoked by driving the host write and the pulse in one cycle: directed first, then in a random mix. A behavioural model in the bench resolves each collision the way R12 and R13 specify, and the bench compares read data, command outputs, enables and `irq` after every clock edge. The STOP-versus-IDON and MERR-versus-enable overrides are provoked the same way, by raising the overriding bit while the overridden bit is being set.

// File: rtl/enet_csr_pkg.sv
package enet_csr_pkg;
   localparam int CSR_W   = 16;
   // register 0 bit positions (host-visible layout)
   localparam int B_ERR   = 15;
   localparam int B_INTR  = 7;
   localparam int B_INEA  = 6;
   localparam int B_RXON  = 5;
   localparam int B_TXON  = 4;
   localparam int B_TDMD  = 3;
   localparam int B_STOP  = 2;
   localparam int B_STRT  = 1;
   localparam int B_INIT  = 0;
   // event flags occupy bits EV_LSB .. EV_LSB+EV_N-1
   localparam int EV_LSB  = 8;
   localparam int EV_N    = 7;
   localparam int EV_IDON = 0;
   localparam int EV_TINT = 1;
   localparam int EV_RINT = 2;
   localparam int EV_MERR = 3;
   localparam int EV_MISS = 4;
   localparam int EV_CERR = 5;
   localparam int EV_BABL = 6;
   // which event flags feed each summary bit
   localparam logic [EV_N-1:0] ERR_MASK = 7'b1111000;
   localparam logic [EV_N-1:0] INT_MASK = 7'b1011111;
endpackage

// File: rtl/enet_csr0_core.sv
module enet_csr0_core
   import enet_csr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CSR_W-1:0]  wdata,
   input  logic [EV_N-1:0]   evt_set,
   input  logic              clr_init,
   input  logic              clr_tdmd,
   input  logic              init_rx_en,
   input  logic              init_tx_en,
   output logic [CSR_W-1:0]  csr0_rd,
   output logic              init_o,
   output logic              strt_o,
   output logic              stop_o,
   output logic              tdmd_o,
   output logic              rxon_o,
   output logic              txon_o
);
   logic [EV_N-1:0] ev_q, ev_d, w1c, ev_vis;
   logic stop_q, strt_q, init_q, tdmd_q, inea_q, rxon_q, txon_q;
   logic stop_d, strt_d, init_d, tdmd_d, inea_d, rxon_d, txon_d;
   logic err_sum, int_sum, rx_vis, tx_vis;

   always_comb begin
      w1c    = wr_en ? wdata[EV_LSB +: EV_N] : '0;
      // hardware set is applied after the host clear, so it wins
      ev_d   = (ev_q & ~w1c) | evt_set;
      if (stop_q) ev_d[EV_IDON] = 1'b0;

      tdmd_d = (tdmd_q & ~clr_tdmd) | (wr_en & wdata[B_TDMD]);
      init_d = (init_q & ~clr_init) | (wr_en & wdata[B_INIT]);
      strt_d = strt_q | (wr_en & wdata[B_STRT]);
      stop_d = stop_q;
      if (wr_en && (wdata[B_STRT] || wdata[B_INIT])) stop_d = 1'b0;
      if (wr_en && wdata[B_STOP]) begin
         stop_d = 1'b1;
         strt_d = 1'b0;
         init_d = 1'b0;
      end
      inea_d = wr_en ? wdata[B_INEA] : inea_q;

      rxon_d = clr_init ? init_rx_en : rxon_q;
      txon_d = clr_init ? init_tx_en : txon_q;
      if (ev_q[EV_MERR]) begin
         rxon_d = 1'b0;
         txon_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q   <= '0;
         stop_q <= 1'b1;
         strt_q <= 1'b0;
         init_q <= 1'b0;
         tdmd_q <= 1'b0;
         inea_q <= 1'b0;
         rxon_q <= 1'b0;
         txon_q <= 1'b0;
      end else begin
         ev_q   <= ev_d;
         stop_q <= stop_d;
         strt_q <= strt_d;
         init_q <= init_d;
         tdmd_q <= tdmd_d;
         inea_q <= inea_d;
         rxon_q <= rxon_d;
         txon_q <= txon_d;
      end
   end

   // overrides act on the read side at once, storage follows a cycle later
   always_comb begin
      ev_vis          = ev_q;
      ev_vis[EV_IDON] = ev_q[EV_IDON] & ~stop_q;
      rx_vis          = rxon_q & ~ev_q[EV_MERR];
      tx_vis          = txon_q & ~ev_q[EV_MERR];
      err_sum         = |(ev_vis & ERR_MASK);
      int_sum         = |(ev_vis & INT_MASK);
   end

   always_comb begin
      csr0_rd                      = '0;
      csr0_rd[B_ERR]               = err_sum;
      csr0_rd[EV_LSB +: EV_N]      = ev_vis;
      csr0_rd[B_INTR]              = int_sum;
      csr0_rd[B_INEA]              = inea_q;
      csr0_rd[B_RXON]              = rx_vis;
      csr0_rd[B_TXON]              = tx_vis;
      csr0_rd[B_TDMD]              = tdmd_q;
      csr0_rd[B_STOP]              = stop_q;
      csr0_rd[B_STRT]              = strt_q;
      csr0_rd[B_INIT]              = init_q;
   end

   assign init_o = init_q;
   assign strt_o = strt_q;
   assign stop_o = stop_q;
   assign tdmd_o = tdmd_q;
   assign rxon_o = rx_vis;
   assign txon_o = tx_vis;

   p_stop_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[B_STOP]) |=> (stop_q && !strt_q && !init_q));
   p_w1c_rint_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[EV_LSB+EV_RINT] && !evt_set[EV_RINT]) |=> !ev_q[EV_RINT]);
   p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set[EV_TINT] |=> ev_q[EV_TINT]);
   p_merr_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_q[EV_MERR] |=> (!rxon_q && !txon_q));
   p_stop_idon_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_q |=> !ev_q[EV_IDON]);
   p_tdmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tdmd_q && !clr_tdmd) |=> tdmd_q);
   p_inea_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (inea_q == $past(wdata[B_INEA])));
endmodule

// File: rtl/enet_csr_plain_bank.sv
module enet_csr_plain_bank #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 4,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] bank_w [NUM_REGS];

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      if (k == 0) begin : g_hole
         // slot 0 lives in the command/status core
         assign bank_w[k] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (wr_en && idx == IDX_W'(k))      q <= wdata;
         end
         assign bank_w[k] = q;

         p_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && idx == IDX_W'(k)) |=> (q == $past(wdata)));
      end
   end

   assign rdata = bank_w[idx];
endmodule

// File: rtl/enet_csr_irq_gate.sv
module enet_csr_irq_gate #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic int_sum,
   input  logic int_en,
   output logic irq_o
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= int_sum & int_en;
      end
   end else begin : g_comb
      assign irq_o = int_sum & int_en;
   end
endmodule

// File: rtl/enet_csr_file.sv
module enet_csr_file
   import enet_csr_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 4,
   parameter bit IRQ_REG  = 1'b0,
   localparam int SEL_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [EV_N-1:0]   evt_set,
   input  logic              clr_init,
   input  logic              clr_tdmd,
   input  logic              init_rx_en,
   input  logic              init_tx_en,
   output logic              cmd_init,
   output logic              cmd_strt,
   output logic              cmd_stop,
   output logic              cmd_tdmd,
   output logic              rx_on,
   output logic              tx_on,
   output logic              irq
);
   if (DATA_W != CSR_W) begin : g_bad_width
      $error("enet_csr_file: DATA_W must equal the fixed register layout width");
   end
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_depth
      $error("enet_csr_file: NUM_REGS must be a power of two, at least 2");
   end

   logic [SEL_W-1:0]  sel_q;
   logic [DATA_W-1:0] csr0_rd, bank_rd;
   logic              wr_sel, wr_core, wr_bank;

   assign wr_sel  = bus_wr &  bus_addr;
   assign wr_core = bus_wr & ~bus_addr & (sel_q == '0);
   assign wr_bank = bus_wr & ~bus_addr & (sel_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (wr_sel) sel_q <= bus_wdata[SEL_W-1:0];
   end

   enet_csr0_core u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_core),
      .wdata      (bus_wdata),
      .evt_set    (evt_set),
      .clr_init   (clr_init),
      .clr_tdmd   (clr_tdmd),
      .init_rx_en (init_rx_en),
      .init_tx_en (init_tx_en),
      .csr0_rd    (csr0_rd),
      .init_o     (cmd_init),
      .strt_o     (cmd_strt),
      .stop_o     (cmd_stop),
      .tdmd_o     (cmd_tdmd),
      .rxon_o     (rx_on),
      .txon_o     (tx_on)
   );

   enet_csr_plain_bank #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_bank),
      .idx   (sel_q),
      .wdata (bus_wdata),
      .rdata (bank_rd)
   );

   enet_csr_irq_gate #(
      .REG_OUT (IRQ_REG)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .int_sum (csr0_rd[B_INTR]),
      .int_en  (csr0_rd[B_INEA]),
      .irq_o   (irq)
   );

   always_comb begin
      if (bus_addr)            bus_rdata = {{(DATA_W-SEL_W){1'b0}}, sel_q};
      else if (sel_q == '0)    bus_rdata = csr0_rd;
      else                     bus_rdata = bank_rd;
   end

   p_sel_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> (sel_q == $past(bus_wdata[SEL_W-1:0])));

   if (!IRQ_REG) begin : g_irq_chk
      p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !csr0_rd[B_INEA] |-> !irq);
   end
endmodule

// File: tb/enet_csr_file_tb_top.sv
module enet_csr_file_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, bus_wr, bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic [6:0]  evt_set;
   logic        clr_init, clr_tdmd, init_rx_en, init_tx_en;
   logic        cmd_init, cmd_strt, cmd_stop, cmd_tdmd, rx_on, tx_on, irq;

   enet_csr_file dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
      .clr_init(clr_init), .clr_tdmd(clr_tdmd), .init_rx_en(init_rx_en),
      .init_tx_en(init_tx_en), .cmd_init(cmd_init), .cmd_strt(cmd_strt),
      .cmd_stop(cmd_stop), .cmd_tdmd(cmd_tdmd), .rx_on(rx_on), .tx_on(tx_on),
      .irq(irq)
   );

   int    checks = 0, errors = 0;
   string cur_req = "R1";
   bit    done = 0;

   // behavioural reference state
   logic [6:0] m_ev;   // index: 6 BABL 5 CERR 4 MISS 3 MERR 2 RINT 1 TINT 0 IDON
   logic m_stop, m_strt, m_init, m_tdmd, m_inea, m_rx, m_tx;
   int   m_sel;
   int   m_bank[4];

   function automatic logic [15:0] exp_csr0();
      logic [6:0] e;
      logic er, it;
      e = m_ev;
      if (m_stop) e[0] = 1'b0;
      er = e[6] | e[5] | e[4] | e[3];
      it = e[6] | e[4] | e[3] | e[2] | e[1] | e[0];
      return {er, e, it, m_inea, m_rx & ~m_ev[3], m_tx & ~m_ev[3],
              m_tdmd, m_stop, m_strt, m_init};
   endfunction

   task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      logic [15:0] c0, rd;
      c0 = exp_csr0();
      if (bus_addr)         rd = 16'(m_sel);
      else if (m_sel == 0)  rd = c0;
      else                  rd = 16'(m_bank[m_sel]);
      chk("rdata", bus_rdata, rd);
      chk("outputs", {9'b0, irq, cmd_init, cmd_strt, cmd_stop, cmd_tdmd, rx_on, tx_on},
          {9'b0, c0[7] & c0[6], m_init, m_strt, m_stop, m_tdmd, c0[5], c0[4]});
   endtask

   task automatic cyc(input logic wr, input logic a, input logic [15:0] wd,
                      input logic [6:0] es = 7'b0, input logic ci = 1'b0,
                      input logic ct = 1'b0, input logic rxe = 1'b0,
                      input logic txe = 1'b0);
      logic [6:0] n_ev;
      logic n_stop, n_strt, n_init, n_tdmd, n_inea, n_rx, n_tx, w0;
      int   n_sel;
      bus_wr = wr; bus_addr = a; bus_wdata = wd; evt_set = es;
      clr_init = ci; clr_tdmd = ct; init_rx_en = rxe; init_tx_en = txe;
      w0 = wr && !a && (m_sel == 0);
      n_ev = m_ev;
      if (w0) n_ev = n_ev & ~wd[14:8];
      n_ev = n_ev | es;
      if (m_stop) n_ev[0] = 1'b0;
      n_tdmd = m_tdmd; n_init = m_init; n_strt = m_strt; n_stop = m_stop;
      if (ct) n_tdmd = 1'b0;
      if (ci) n_init = 1'b0;
      n_inea = m_inea;
      if (w0) begin
         if (wd[3]) n_tdmd = 1'b1;
         if (wd[1]) begin n_strt = 1'b1; n_stop = 1'b0; end
         if (wd[0]) begin n_init = 1'b1; n_stop = 1'b0; end
         if (wd[2]) begin n_stop = 1'b1; n_strt = 1'b0; n_init = 1'b0; end
         n_inea = wd[6];
      end
      n_rx = ci ? rxe : m_rx;
      n_tx = ci ? txe : m_tx;
      if (m_ev[3]) begin n_rx = 1'b0; n_tx = 1'b0; end
      n_sel = m_sel;
      if (wr && a) n_sel = int'(wd[1:0]);
      @(posedge clk);
      if (wr && !a && m_sel != 0) m_bank[m_sel] = int'(wd);
      m_ev = n_ev; m_stop = n_stop; m_strt = n_strt; m_init = n_init;
      m_tdmd = n_tdmd; m_inea = n_inea; m_rx = n_rx; m_tx = n_tx; m_sel = n_sel;
      @(negedge clk);
      compare_all();
      bus_wr = 1'b0; evt_set = '0; clr_init = 1'b0; clr_tdmd = 1'b0;
   endtask

   task automatic wsel(input logic [15:0] v); cyc(1'b1, 1'b1, v); endtask
   task automatic wdat(input logic [15:0] v); cyc(1'b1, 1'b0, v); endtask
   task automatic look(input logic a);        cyc(1'b0, a, 16'h0); endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_up();
   end

   initial begin
      rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; evt_set = 0;
      clr_init = 0; clr_tdmd = 0; init_rx_en = 0; init_tx_en = 0;
      m_ev = 0; m_stop = 1; m_strt = 0; m_init = 0; m_tdmd = 0; m_inea = 0;
      m_rx = 0; m_tx = 0; m_sel = 0;
      for (int i = 0; i < 4; i++) m_bank[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      cur_req = "R1";
      compare_all();
      chk("csr0 after reset R1", bus_rdata, 16'h0004);
      look(1'b1);
      look(1'b0);

      // R11: plain registers hold full words
      cur_req = "R11";
      wsel(16'd1); wdat(16'hA5C3);
      wsel(16'd2); wdat(16'hFFFF);
      wsel(16'd3); wdat(16'h1234);
      wsel(16'd1); look(1'b0);
      wsel(16'd3); look(1'b0);

      // R2: select masked to two bits
      cur_req = "R2";
      wsel(16'hFFF6); look(1'b1); look(1'b0);
      wsel(16'h0004); look(1'b1); look(1'b0);

      // R12: hardware event sets
      cur_req = "R12";
      cyc(1'b0, 1'b0, 16'h0, 7'b0000010);
      cyc(1'b0, 1'b0, 16'h0, 7'b0000100);

      // R8: CERR alone raises ERR but not INTR
      cur_req = "R8";
      wdat(16'h7F00);
      cyc(1'b0, 1'b0, 16'h0, 7'b0100000);
      // R7: MISS raises ERR
      cur_req = "R7";
      cyc(1'b0, 1'b0, 16'h0, 7'b0010000);

      // R3: write-one-to-clear, zeros ignored
      cur_req = "R3";
      wdat(16'h0000);
      wdat(16'h2000);
      // R12: clear and set collide, set wins
      cur_req = "R12";
      cyc(1'b1, 1'b0, 16'h1000, 7'b0010000);
      chk("MISS survives collision R12", bus_rdata & 16'h1000, 16'h1000);

      // R6 / R10: enable gating
      cur_req = "R6";
      wdat(16'h0040);
      cur_req = "R10";
      chk("irq with MISS and INEA R10", {15'b0, irq}, 16'h0001);
      wdat(16'h0000);
      wdat(16'h1040);
      cyc(1'b0, 1'b0, 16'h0, 7'b0000010);
      wdat(16'h0240);

      // R4: set-only commands, STRT and INIT release STOP
      cur_req = "R4";
      wdat(16'h0002);
      wdat(16'h0000);
      wdat(16'h0008);
      wdat(16'h0000);
      cyc(1'b0, 1'b0, 16'h0, 7'b0, 1'b0, 1'b1);
      wdat(16'h0004);
      wdat(16'h0001);
      chk("INIT clears STOP R4", {15'b0, cmd_stop}, 16'h0000);

      // R13: init completion and collisions with host sets
      cur_req = "R13";
      cyc(1'b0, 1'b0, 16'h0, 7'b0, 1'b1, 1'b0, 1'b1, 1'b1);
      wdat(16'h0001);
      cyc(1'b1, 1'b0, 16'h0001, 7'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 16'h0008, 7'b0, 1'b0, 1'b1);
      cyc(1'b0, 1'b0, 16'h0, 7'b0, 1'b1, 1'b1, 1'b1, 1'b1);

      // R9: MERR forces enables off, STOP suppresses IDON
      cur_req = "R9";
      cyc(1'b0, 1'b0, 16'h0, 7'b0001000);
      chk("rx_on off under MERR R9", {15'b0, rx_on}, 16'h0000);
      look(1'b0);
      cyc(1'b0, 1'b0, 16'h0, 7'b0, 1'b1, 1'b0, 1'b1, 1'b1);
      wdat(16'h0800);
      cyc(1'b0, 1'b0, 16'h0, 7'b0, 1'b1, 1'b0, 1'b1, 1'b1);

      // R5: STOP wins over STRT and INIT in one write
      cur_req = "R5";
      wdat(16'h0007);
      cur_req = "R9";
      cyc(1'b0, 1'b0, 16'h0, 7'b0000001);
      wdat(16'h0002);
      cyc(1'b0, 1'b0, 16'h0, 7'b0000001);
      wdat(16'h0044);
      chk("IDON hidden under STOP R9", bus_rdata & 16'h0100, 16'h0000);
      wdat(16'h0002);

      // random mix of host writes and engine pulses
      cur_req = "R12";
      for (int i = 0; i < 400; i++) begin
         logic [15:0] wd;
         logic wr, a;
         wd = 16'($urandom);
         wr = ($urandom % 3) != 0;
         a  = ($urandom % 6) == 0;
         if (($urandom % 4) != 0) wd[2] = 1'b0;
         cyc(wr, a, wd, 7'($urandom) & 7'($urandom), ($urandom % 5) == 0,
             ($urandom % 5) == 0, 1'($urandom), 1'($urandom));
      end

      finish_up();
   end
endmodule